// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a single line. It uses an oversampling tick at sixteen times the bit rate, which comes from a baud generator outside the block. Each frame holds a low start bit, eight data bits with the least significant bit first, an optional ninth bit, and a high stop bit. When a frame completes, the block presents the byte and the ninth bit and raises a ready flag. The flag stays up until software clears it.

In a shared-bus system, several receivers listen to the same line, and a host sends address frames to select one or more of them. With filtering enabled, a receiver raises its ready flag only for frames addressed to it, so a node is never disturbed by traffic for other nodes. A frame is addressed to the node when it matches one of two addresses:

- The node's masked individual address.
- A broadcast address, built from the same two registers.

In 8-bit mode the stop bit takes the place of the ninth bit, so a filtered frame must also end with a valid stop bit.

Top module: `uart_addr_rx`

## Requirements
- R1: In 9-bit mode (`nine_mode`=1), a frame is a start bit (0), then data bits D0..D7 with D0 first, then a ninth bit, then a stop bit. On acceptance, `rx_data` holds D7..D0 and `rx_bit9` holds the ninth bit.
- R2: In 8-bit mode (`nine_mode`=0), a frame is start, D0..D7, stop. The stop bit value is loaded into `rx_bit9`.
- R3: With `filt_en`=0, every completed frame raises `ready` and loads `rx_data` and `rx_bit9`. This holds even when the stop bit is low.
- R4: With `filt_en`=1 in 9-bit mode, a frame is accepted only if its ninth bit is 1 and its byte hits the given or broadcast address. Any other frame leaves `ready`, `rx_data` and `rx_bit9` untouched.
- R5: The byte hits the given address when it equals `addr` in every bit position where `mask` is 1. Example: `addr`=0x56 and `mask`=0xFC match 0x54..0x57. With `mask`=0xFF, only 0x56 matches.
- R6: The broadcast address is `addr | mask`. The byte hits it when it has a 1 in every bit position where `addr | mask` is 1. A `mask` of 0x00 accepts every byte.
- R7: With `filt_en`=1 in 8-bit mode, a frame is accepted only if its byte hits an address and its stop bit is 1.
- R8: At the end of every frame, accepted or not, `frame_err` is loaded with the inverse of the stop bit value. Between frames it does not change.
- R9: Each bit value is the majority of oversampling samples 7, 8 and 9, counted from the tick on which the start edge is first seen. A start bit that votes high is taken as a glitch, and the receiver returns to idle without effect.
- R10: `ready` stays at 1 until `clr_ready` is asserted. While `ready` is 1, a newly accepted frame does not overwrite `rx_data` or `rx_bit9`.
- R11: A `clr_ready` pulse clears `ready` on the next clock edge, unless a frame is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| nine_mode | input | 1 | 1: frame carries a ninth bit; 0: 8-bit frame |
| filt_en | input | 1 | Enables address filtering |
| addr | input | 8 | Individual address of this node |
| mask | input | 8 | Address mask; 0 bits are don't-care |
| clr_ready | input | 1 | Software clear of the ready flag |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in 8-bit mode |
| ready | output | 1 | Receive-ready flag |
| frame_err | output | 1 | Stop bit of the last frame was low |

## Verification
The bench builds the block with its defaults: 16 samples per bit and an 8-bit byte. It drives a tick every third clock, so a 11-bit frame takes about 530 cycles, and a few dozen frames fit comfortably in the run.

Because the bench moves the line just after a tick, it can place a one-tick spike on exactly one of the three voting samples, which tests the majority decision. It can also cut the start bit short so that the start vote fails.

The address tests use a mask of 0xFC, 0xFF and 0x00 with address 0x56. These values cover the given address, the exact match and the match-all case. Under mask 0xFC, bytes 0xFE and 0xFF hit the broadcast address.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          nine_mode,
  input  logic          filt_en,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] mask,
  input  logic          clr_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          ready,
  output logic          frame_err
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 4);
  localparam logic [CW-1:0] S0   = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] S1   = CW'(OVS/2);
  localparam logic [CW-1:0] S2   = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] CTOP = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST8 = BW'(DW + 1);
  localparam logic [BW-1:0] LAST9 = BW'(DW + 2);
  localparam logic [BW-1:0] DTOP  = BW'(DW);

  logic          rxd_m, rxd_s;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic          v0, v1;
  logic [DW-1:0] sh;
  logic          b9;

  logic          maj, at_dec, done, bit9v, hit_given, hit_bcast, accept;
  logic [BW-1:0] last;
  logic [DW-1:0] bmask;

  assign maj       = (v0 & v1) | (v0 & rxd_s) | (v1 & rxd_s);
  assign last      = nine_mode ? LAST9 : LAST8;
  assign at_dec    = busy && tick && (cnt == S2);
  assign done      = at_dec && (bitn == last);
  assign bit9v     = nine_mode ? b9 : maj;
  assign bmask     = addr | mask;
  assign hit_given = ((sh ^ addr) & mask) == '0;
  assign hit_bcast = (sh & bmask) == bmask;
  assign accept    = done && (!filt_en || (bit9v && (hit_given || hit_bcast)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m     <= 1'b1;
      rxd_s     <= 1'b1;
      busy      <= 1'b0;
      cnt       <= '0;
      bitn      <= '0;
      v0        <= 1'b1;
      v1        <= 1'b1;
      sh        <= '0;
      b9        <= 1'b0;
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      ready     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
      if (tick) begin
        if (!busy) begin
          if (!rxd_s) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
            bitn <= '0;
          end
        end else begin
          cnt <= (cnt == CTOP) ? '0 : cnt + CW'(1);
          if (cnt == S0) v0 <= rxd_s;
          if (cnt == S1) v1 <= rxd_s;
          if (cnt == S2) begin
            if (bitn == '0) begin
              if (maj) busy <= 1'b0;
            end else if (bitn == last) begin
              busy <= 1'b0;
            end else if (bitn <= DTOP) begin
              sh <= {maj, sh[DW-1:1]};
            end else begin
              b9 <= maj;
            end
          end
          if (cnt == CTOP) bitn <= bitn + BW'(1);
        end
      end
      if (done) frame_err <= ~maj;
      if (accept && !ready) begin
        ready   <= 1'b1;
        rx_data <= sh;
        rx_bit9 <= bit9v;
      end else if (clr_ready) begin
        ready <= 1'b0;
      end
    end
  end
endmodule

module uart_addr_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_ready,
  input logic          filt_en,
  input logic          nine_mode,
  input logic [DW-1:0] addr,
  input logic [DW-1:0] mask,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9,
  input logic          ready,
  input logic          frame_err,
  input logic          done
);
  logic hit;
  assign hit = (((rx_data ^ addr) & mask) == '0) ||
               ((rx_data & (addr | mask)) == (addr | mask));

  p_ready_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(done));

  p_ninth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) && $past(filt_en) && $past(nine_mode) |-> rx_bit9 && hit);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) && $past(filt_en) && !$past(nine_mode) |-> rx_bit9 && hit);

  p_ferr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err) |-> $past(done));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !clr_ready |=> ready && $stable(rx_data) && $stable(rx_bit9));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ready && !done |=> !ready);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_ready(clr_ready), .filt_en(filt_en),
  .nine_mode(nine_mode), .addr(addr), .mask(mask), .rx_data(rx_data),
  .rx_bit9(rx_bit9), .ready(ready), .frame_err(frame_err), .done(done)
);

// File: tb/sim_uart_addr_rx.sv
`timescale 1ns/1ps
module sim_uart_addr_rx;
  localparam int TDIV = 3;
  localparam int OVS  = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic nine_mode = 1'b1, filt_en = 1'b0, clr_ready = 1'b0;
  logic [7:0] addr = 8'h00, mask = 8'h00;
  logic [7:0] rx_data;
  logic rx_bit9, ready, frame_err;

  int errors = 0, checks = 0, nrdy = 0, npush = 0;
  bit auto_clr = 1'b1, hold = 1'b0, held = 1'b0, done_flag = 1'b0;
  logic [7:0] q_data[$];
  logic       q_b9[$];
  string      q_tag[$];

  always #2.5 clk = ~clk;

  uart_addr_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_mode(nine_mode),
    .filt_en(filt_en), .addr(addr), .mask(mask), .clr_ready(clr_ready),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .ready(ready), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      repeat (TDIV-1) @(negedge clk);
      tick <= 1'b1;
      @(negedge clk);
      tick <= 1'b0;
    end
  end

  task automatic wait_tick();
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  function automatic bit model_accept(input logic [7:0] d, input logic b9v);
    logic [7:0] bm;
    bm = addr | mask;
    return !filt_en || (b9v && ((((d ^ addr) & mask) == 8'h00) || ((d & bm) == bm)));
  endfunction

  task automatic drive_bit(input logic v, input bit glitch);
    rxd <= v;
    for (int t = 0; t < OVS; t++) begin
      wait_tick();
      if (glitch && t == 7) rxd <= ~v;
      if (glitch && t == 8) rxd <= v;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stp,
                      input string tag, input int gbit);
    logic b9v;
    int idx;
    b9v = nine_mode ? b9 : stp;
    if (model_accept(d, b9v) && !(hold && held)) begin
      q_data.push_back(d); q_b9.push_back(b9v); q_tag.push_back(tag);
      npush++;
      if (hold) held = 1'b1;
    end
    wait_tick();
    drive_bit(1'b0, gbit == 0);
    idx = 1;
    for (int i = 0; i < 8; i++) begin
      drive_bit(d[i], gbit == idx);
      idx++;
    end
    if (nine_mode) begin
      drive_bit(b9, gbit == idx);
      idx++;
    end
    drive_bit(stp, gbit == idx);
    rxd <= 1'b1;
    repeat (2*OVS) wait_tick();
    chk(frame_err == !stp, {tag, " R8 frame_err"}, frame_err, !stp);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (ready && auto_clr) begin
        nrdy++;
        if (q_data.size() == 0) begin
          chk(1'b0, "R4 unexpected ready", rx_data, 0);
        end else begin
          string tg;
          logic [7:0] ed;
          logic eb;
          tg = q_tag.pop_front(); ed = q_data.pop_front(); eb = q_b9.pop_front();
          chk(rx_data == ed, {tg, " rx_data"}, rx_data, ed);
          chk(rx_bit9 == eb, {tg, " rx_bit9"}, rx_bit9, eb);
        end
        clr_ready <= 1'b1;
        @(negedge clk);
        clr_ready <= 1'b0;
        chk(ready == 1'b0, "R11 clear", ready, 0);
      end
    end
  end

  initial begin
    #(180000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "reset ready", ready, 0);
    chk(frame_err == 1'b0, "reset frame_err", frame_err, 0);
    chk(rx_data == 8'h00, "reset rx_data", rx_data, 0);
    rst_n <= 1'b1;
    repeat (5) @(negedge clk);

    nine_mode = 1; filt_en = 0;
    send(8'hA5, 1'b0, 1'b1, "R1 R3 9b", -1);
    send(8'h3C, 1'b1, 1'b1, "R1 R3 9b", -1);
    send(8'h81, 1'b1, 1'b0, "R3 stop low", -1);

    nine_mode = 0;
    send(8'h5A, 1'b0, 1'b1, "R2 8b", -1);
    send(8'h11, 1'b0, 1'b0, "R2 R8 8b stop low", -1);

    nine_mode = 1; filt_en = 1; addr = 8'h56; mask = 8'hFC;
    send(8'h55, 1'b1, 1'b1, "R5 given", -1);
    send(8'h57, 1'b1, 1'b1, "R5 given", -1);
    send(8'h5A, 1'b1, 1'b1, "R4 miss", -1);
    send(8'hFE, 1'b1, 1'b1, "R6 bcast", -1);
    send(8'hFF, 1'b1, 1'b1, "R6 bcast", -1);
    send(8'h55, 1'b0, 1'b1, "R4 data frame", -1);
    mask = 8'hFF;
    send(8'h56, 1'b1, 1'b1, "R5 exact", -1);
    send(8'h57, 1'b1, 1'b1, "R5 exact miss", -1);
    mask = 8'h00;
    send(8'h12, 1'b1, 1'b1, "R6 all-zero mask", -1);

    nine_mode = 0; mask = 8'hFC;
    send(8'h54, 1'b0, 1'b1, "R7 stop ok", -1);
    send(8'h54, 1'b0, 1'b0, "R7 stop bad", -1);
    send(8'h99, 1'b0, 1'b1, "R7 miss", -1);

    nine_mode = 1; filt_en = 0;
    send(8'hC3, 1'b1, 1'b1, "R9 data spike", 4);
    send(8'h0F, 1'b0, 1'b1, "R9 start spike", 0);
    send(8'h70, 1'b1, 1'b1, "R9 ninth spike", 9);

    n0 = nrdy;
    wait_tick();
    rxd <= 1'b0;
    repeat (5) wait_tick();
    rxd <= 1'b1;
    repeat (3*OVS) wait_tick();
    chk(nrdy == n0, "R9 short start", nrdy, n0);
    chk(ready == 1'b0, "R9 short start ready", ready, 0);

    auto_clr = 0; hold = 1; held = 0;
    send(8'h21, 1'b1, 1'b1, "R10 first", -1);
    send(8'h42, 1'b0, 1'b1, "R10 second", -1);
    chk(ready == 1'b1, "R10 held ready", ready, 1);
    chk(rx_data == 8'h21, "R10 held data", rx_data, 8'h21);
    chk(rx_bit9 == 1'b1, "R10 held bit9", rx_bit9, 1);
    hold = 0; auto_clr = 1;
    repeat (20) @(negedge clk);

    chk(q_data.size() == 0, "R4 queue drained", q_data.size(), 0);
    chk(nrdy == npush, "R4 ready count", nrdy, npush);
    finish_run();
  end
endmodule